// File: doc/BRIEF.md
# Subtract-Based Compare Unit

This block compares two operands and produces a four-bit condition field holding less-than, greater-than and equal flags plus a copy of the current summary-overflow bit. It works on full 64-bit operands or on their low 32 bits, and it treats them as signed or unsigned. A separate flag picks signed or unsigned; the operation code does not.

The ordering comes from one adder that forms NOT A + B + 1, which is B minus A. The less-than and greater-than flags are built from the sign of that difference, its carry-out and the sign bits of both operands. In 32-bit mode the carry out of bit 31 and the bit-31 signs are used. In 64-bit mode the full carry and the bit-63 signs are used. Equality does not come from the adder: a separate comparator tests the operands directly.

The result passes through an output register with a written-out clock enable. A parameter can drop that register and leave the block purely combinational.

Top module: `sub_cmp_unit`

## Requirements
- R1: In 64-bit mode (word_mode=0), cond_out[1] (EQ) is 1 exactly when op_a equals op_b over all 64 bits.
- R2: In 32-bit mode (word_mode=1), bits 63:32 of both operands have no effect on cond_out; only bits 31:0 are compared.
- R3: Unsigned 64-bit mode (is_signed=0, word_mode=0): cond_out[3] (LT) is 1 when op_a < op_b, and cond_out[2] (GT) is 1 when op_a > op_b, both as unsigned values.
- R4: Signed 64-bit mode (is_signed=1, word_mode=0): LT and GT follow two's-complement ordering of op_a against op_b, including operands whose signs differ.
- R5: Signed 32-bit mode: LT and GT follow two's-complement ordering of op_a[31:0] against op_b[31:0].
- R6: Unsigned 32-bit mode: LT and GT follow unsigned ordering of op_a[31:0] against op_b[31:0].
- R7: Exactly one of cond_out[3:1] is 1 for every captured compare.
- R8: cond_out[0] is a copy of so_in taken in the same cycle as the operands.
- R9: cond_out is registered. It takes the compare of the inputs at a rising clk edge where en=1, and holds its value at edges where en=0.
- R10: While rst_n is low, cond_out is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable for the result register |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| is_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| word_mode | input | 1 | 1 = compare bits 31:0, 0 = compare all 64 bits |
| so_in | input | 1 | Current summary-overflow bit |
| cond_out | output | 4 | {LT, GT, EQ, SO} |

## Verification
The operand pairs cover five separate cases:
- equal values;
- unsigned pairs where only the carry decides the order;
- signed pairs with opposite signs, where the sign bits decide;
- signed pairs with matching signs, where the sign of the difference decides;
- the most-negative value against the most-positive one, which swaps its answer between signed and unsigned.

Word-mode vectors set the upper halves so that a 64-bit compare would give a different answer from a 32-bit one. This shows that the bit-31 carry and bit-31 signs are the ones in use. Directed steps then show that the result holds while the enable is low, and that reset clears the field.

// File: rtl/sub_cmp_pkg.sv
package sub_cmp_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

endpackage

// File: rtl/cmp_sub_adder.sv
// Single adder forming ~A + B + 1 (B minus A), split at the half-width
// boundary so that the low-half carry is available for 32-bit mode.
module cmp_sub_adder #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         cout_full_o,
  output logic         cout_half_o
);
  localparam int UW = W - HW;

  logic [HW:0] lo_sum;
  logic [UW:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, ~a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, 1'b1};
    hi_sum = {1'b0, ~a_i[W-1:HW]} + {1'b0, b_i[W-1:HW]} + {{UW{1'b0}}, lo_sum[HW]};
  end

  assign diff_o      = {hi_sum[UW-1:0], lo_sum[HW-1:0]};
  assign cout_half_o = lo_sum[HW];
  assign cout_full_o = hi_sum[UW];

endmodule

// File: rtl/cmp_eq.sv
// Direct operand equality, independent of the adder.
module cmp_eq #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         word_mode_i,
  output logic         eq_o
);
  logic eq_lo;
  logic eq_hi;

  always_comb begin
    eq_lo = (a_i[HW-1:0] == b_i[HW-1:0]);
    eq_hi = (a_i[W-1:HW] == b_i[W-1:HW]);
    eq_o  = eq_lo & (word_mode_i | eq_hi);
  end

endmodule

// File: rtl/cmp_order.sv
// Ordering flags from the difference sign, carry-out and operand signs.
module cmp_order (
  input  logic sign_a_i,
  input  logic sign_b_i,
  input  logic diff_msb_i,
  input  logic carry_i,
  input  logic eq_i,
  input  logic is_signed_i,
  output logic lt_o,
  output logic gt_o
);
  always_comb begin
    if (!is_signed_i) begin
      // carry set means no borrow: B >= A
      lt_o = carry_i & ~eq_i;
      gt_o = ~carry_i;
    end else if (sign_a_i != sign_b_i) begin
      lt_o = sign_a_i;
      gt_o = sign_b_i;
    end else begin
      // same signs: B - A cannot overflow
      lt_o = ~diff_msb_i & ~eq_i;
      gt_o = diff_msb_i;
    end
  end

endmodule

// File: rtl/sub_cmp_unit.sv
module sub_cmp_unit
  import sub_cmp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter bit REG_OUT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              is_signed,
  input  logic              word_mode,
  input  logic              so_in,
  output logic [3:0]        cond_out
);
  localparam int MSB_F = DATA_W - 1;
  localparam int MSB_H = HALF_W - 1;

  // reset: asserted asynchronously, released on clk
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1] & rst_n;

  logic [DATA_W-1:0] diff;
  logic              cout_full;
  logic              cout_half;
  logic              eq_w;
  logic              lt_w;
  logic              gt_w;
  logic              sign_a;
  logic              sign_b;
  logic              diff_msb;
  logic              carry_sel;
  cond_t             cond_d;

  cmp_sub_adder #(.W(DATA_W), .HW(HALF_W)) u_adder (
    .a_i         (op_a),
    .b_i         (op_b),
    .diff_o      (diff),
    .cout_full_o (cout_full),
    .cout_half_o (cout_half)
  );

  cmp_eq #(.W(DATA_W), .HW(HALF_W)) u_eq (
    .a_i         (op_a),
    .b_i         (op_b),
    .word_mode_i (word_mode),
    .eq_o        (eq_w)
  );

  always_comb begin
    if (word_mode) begin
      sign_a    = op_a[MSB_H];
      sign_b    = op_b[MSB_H];
      diff_msb  = diff[MSB_H];
      carry_sel = cout_half;
    end else begin
      sign_a    = op_a[MSB_F];
      sign_b    = op_b[MSB_F];
      diff_msb  = diff[MSB_F];
      carry_sel = cout_full;
    end
  end

  cmp_order u_order (
    .sign_a_i    (sign_a),
    .sign_b_i    (sign_b),
    .diff_msb_i  (diff_msb),
    .carry_i     (carry_sel),
    .eq_i        (eq_w),
    .is_signed_i (is_signed),
    .lt_o        (lt_w),
    .gt_o        (gt_w)
  );

  always_comb begin
    cond_d.lt = lt_w;
    cond_d.gt = gt_w;
    cond_d.eq = eq_w;
    cond_d.so = so_in;
  end

  generate
    if (REG_OUT) begin : g_reg
      cond_t cond_q;
      cond_t cond_nxt;

      always_comb begin
        cond_nxt = cond_q;
        if (en) cond_nxt = cond_d;
      end

      always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) cond_q <= '0;
        else            cond_q <= cond_nxt;
      end

      assign cond_out = cond_q;

      // R9
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        !en |=> $stable(cond_out));

      // R9
      capture_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        en |=> (cond_out == $past(cond_d)));

      // R8
      so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        en |=> (cond_out[0] == $past(so_in)));
    end else begin : g_comb
      assign cond_out = cond_d;
    end
  endgenerate

  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones({lt_w, gt_w, eq_w}) == 1);

  // R1
  eq_full_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!word_mode && (op_a == op_b)) |-> eq_w);

  // R3
  ult_full_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!word_mode && !is_signed && (op_a < op_b)) |-> lt_w);

  // R4
  slt_full_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!word_mode && is_signed && ($signed(op_a) > $signed(op_b))) |-> gt_w);

endmodule

// File: tb/sub_cmp_unit_bench.sv
module sub_cmp_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [63:0] op_a;
  logic [63:0] op_b;
  logic        is_signed;
  logic        word_mode;
  logic        so_in;
  logic [3:0]  cond_out;

  int checks;
  int errors;

  sub_cmp_unit u_sub_cmp_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .word_mode (word_mode),
    .so_in     (so_in),
    .cond_out  (cond_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {a, b, signed, word, so, expected {LT,GT,EQ,SO}}
  localparam int NV = 14;
  localparam logic [134:0] VEC [NV] = '{
    {64'h5, 64'h5, 1'b0, 1'b0, 1'b0, 4'b0010},                                   // R1
    {64'h3, 64'h7, 1'b0, 1'b0, 1'b0, 4'b1000},                                   // R3
    {64'hFFFFFFFFFFFFFFFF, 64'h1, 1'b0, 1'b0, 1'b0, 4'b0100},                    // R3
    {64'hFFFFFFFFFFFFFFFF, 64'h1, 1'b1, 1'b0, 1'b0, 4'b1000},                    // R4
    {64'h1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b1, 4'b0101},                    // R4 R8
    {64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'b1000},     // R4
    {64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 4'b0100},     // R3
    {64'h0000000100000005, 64'h0000000200000005, 1'b0, 1'b1, 1'b0, 4'b0010},     // R2
    {64'h0000000080000000, 64'h0000000000000001, 1'b1, 1'b1, 1'b0, 4'b1000},     // R5
    {64'h0000000080000000, 64'h0000000000000001, 1'b0, 1'b1, 1'b0, 4'b0100},     // R6
    {64'hFFFFFFFF00000002, 64'h0000000000000003, 1'b0, 1'b1, 1'b0, 4'b1000},     // R6
    {64'hFFFFFFFFFFFFFFFB, 64'hFFFFFFFFFFFFFFFD, 1'b1, 1'b0, 1'b0, 4'b1000},     // R4
    {64'hFFFFFFFF7FFFFFFF, 64'h000000007FFFFFFE, 1'b1, 1'b1, 1'b1, 4'b0101},     // R5 R8
    {64'h0, 64'h0, 1'b0, 1'b0, 1'b1, 4'b0011}                                    // R1 R8
  };

  function automatic string tag_of(int idx);
    case (idx)
      0, 13:         return "R1";
      1, 2, 6:       return "R3";
      3, 4, 5, 11:   return "R4";
      7:             return "R2";
      8, 12:         return "R5";
      default:       return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic s, input logic w, input logic so, input logic e);
    op_a = a; op_b = b; is_signed = s; word_mode = w; so_in = so; en = e;
  endtask

  // R7: exactly one ordering flag
  task automatic check_one(input logic [3:0] got);
    checks++;
    if ($countones(got[3:1]) != 1) begin
      errors++;
      $display("FAIL R7 got=%b expected one of LT/GT/EQ set", got);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    drive(64'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 during reset", cond_out, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][134:71], VEC[i][70:7], VEC[i][6], VEC[i][5], VEC[i][4], 1'b1);
      @(posedge clk);
      @(negedge clk);
      check(tag_of(i), cond_out, VEC[i][3:0]);
      check_one(cond_out);
    end

    // R2: upper halves differ wildly, low halves equal in word mode
    drive(64'hDEADBEEF00001234, 64'h0123456700001234, 1'b1, 1'b1, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R2 upper bits ignored", cond_out, 4'b0010);

    // R9: hold while en low
    drive(64'h9, 64'h1, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R9 capture", cond_out, 4'b0100);
    drive(64'h1, 64'h9, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9 hold en=0", cond_out, 4'b0100);
    @(posedge clk); @(negedge clk);
    check("R9 hold second edge", cond_out, 4'b0100);
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 capture after hold", cond_out, 4'b1001);

    // R8: so toggles alone
    so_in = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 so cleared", cond_out, 4'b1000);

    // R10: reset mid-run clears the field
    rst_n = 1'b0;
    #1;
    check("R10 async clear", cond_out, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 recovers", cond_out, 4'b1000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule